// File: doc/BRIEF.md
# Four-Channel DMA Sequencer

This block is the register and sequencing half of a four-channel DMA controller. Each channel holds a programmed source, destination, unit count and control half-word, written through a simple address/data/strobe port. The block also keeps a working copy of each channel's source, destination and remaining count. An enable bit that rises from 0 to 1 arms the channel. A fixed-priority arbiter then hands one transfer unit at a time to an external transfer engine, which does the memory traffic.

For each unit the sequencer pulses `xferStart` and presents the active channel's working addresses, remaining count and control. The engine answers with a one-cycle `unitDone` and the updated source, destination and count. The sequencer writes these back. When the count reaches zero it finishes the channel: it clears or keeps the enable, may reload the working destination, and may raise that channel's interrupt.

Two count variants exist, picked by a parameter. The wide variant has a 21-bit count field. The narrow variant has a 16-bit count field and a different control mask. Immediate timing is supported. A stub frame-blank input starts channels that use frame-blank timing.

Top module: `dma_sequencer`

## Requirements
- R1: After reset every channel reads a programmed count of 0x200000, zero addresses, zero control and zero remaining count, and `xferStart` and `irq` are low.
- R2: Source and destination writes (`wrSel` 0 and 1) are stored ANDed with 0x0FFFFFFE.
- R3: In the wide variant, a control write (`wrSel` 2) takes the count from `wrData[20:0]`, and a zero field stores 0x200000.
- R4: In the narrow variant the count is `wrData[15:0]`, and a zero field stores 0x4000 on channels 0 to 2 and 0x10000 on channel 3.
- R5: The control half-word is `wrData[31:16]` ANDed with 0xFFE0 (wide) or 0xF7E0 (narrow). It reads back at `rdSel` 2 as `{ctl,16'h0}`.
- R6: Only a 0-to-1 change of the enable bit (control bit 15, `wrData[31]`) arms a channel. Arming copies the programmed source and destination into the working registers and loads the remaining count. Rewriting a channel that is already enabled updates only its programmed values.
- R7: With immediate timing (control bits 13:11 all zero), `xferStart` for the first unit first appears after the 4th rising edge that follows the arming write edge.
- R8: Each unit goes to the lowest-numbered channel that is enabled, has a nonzero remaining count and has no start delay pending. Priority is re-evaluated after every unit.
- R9: When the remaining count reaches zero, the enable bit is cleared unless repeat (control bit 9) is set and the timing is not immediate. The cleared enable reads back as 0.
- R10: If destination control (control bits 6:5) equals 3, the working destination reloads from the programmed destination at completion.
- R11: If interrupt enable (control bit 14) is set, completion raises only that channel's `irq` bit for exactly one cycle, in the cycle after the final `unitDone`.
- R12: `xferStart` is a one-cycle pulse. A `unitDone` writes the engine's source, destination and count into the active channel's working registers.
- R13: With frame-blank timing (wide: bits 13:11 = 001, narrow: bits 13:12 = 01), arming leaves the remaining count at 0. A `vblankTick` then loads the programmed count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrChan | input | 2 | Channel written |
| wrSel | input | 2 | 0 source, 1 destination, 2 control and count |
| wrData | input | 32 | Write data |
| rdChan | input | 2 | Channel read |
| rdSel | input | 3 | 0 src, 1 dst, 2 ctl, 3 count, 4 remaining, 5 working src, 6 working dst |
| rdData | output | 32 | Read data (combinational) |
| vblankTick | input | 1 | Frame-blank trigger stub |
| xferStart | output | 1 | Start one unit on the engine |
| xferChan | output | 2 | Active channel |
| xferSrc | output | 32 | Working source of the active channel |
| xferDst | output | 32 | Working destination of the active channel |
| xferCount | output | 22 | Remaining count of the active channel |
| xferCtl | output | 16 | Control of the active channel |
| unitDone | input | 1 | Engine finished one unit |
| doneSrc | input | 32 | Updated source |
| doneDst | input | 32 | Updated destination |
| doneCount | input | 22 | Updated remaining count |
| irq | output | 4 | Per-channel completion interrupt pulse |

## Verification
The bench measures how many cycles pass between an arming write and the first start. A missing or shortened start delay shows up as an early pulse. It rewrites an enabled channel: a design that re-armed on every write would reload the working source and restart the count. It records the order of units when two channels compete and checks that the lower channel takes over between the units of the higher one, which a grant held to completion would not do. It checks completion with repeat set under both immediate and frame-blank timing, and checks the reload of the working destination and the interrupt. A design that kept the enable, skipped the reload or raised the interrupt on the wrong channel would read back wrong values.

// File: rtl/dmaseq_pkg.sv
package dmaseq_pkg;
  localparam int NUM_CH = 4;
  localparam int CH_W = $clog2(NUM_CH);
  localparam int CNT_W = 22;
  localparam logic [1:0] START_WAIT = 2'd3;
  localparam logic [31:0] ADDR_MASK = 32'h0FFF_FFFE;
  localparam logic [CNT_W-1:0] RESET_COUNT = 22'h20_0000;
  localparam int CTL_EN = 15;
  localparam int CTL_IRQ = 14;
  localparam int CTL_REP = 9;

  typedef struct packed {
    logic wb;
    logic finish;
    logic [CH_W-1:0] chan;
  } seqStrobe_t;
endpackage

// File: rtl/dmaseq_regs.sv
module dmaseq_regs
  import dmaseq_pkg::*;
#(
  parameter bit WIDE = 1'b1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [CH_W-1:0]     wrChan,
  input  logic [1:0]          wrSel,
  input  logic [31:0]         wrData,
  input  logic                vblankTick,
  input  seqStrobe_t          strobe,
  input  logic [31:0]         doneSrc,
  input  logic [31:0]         doneDst,
  input  logic [CNT_W-1:0]    doneCount,
  input  logic [CH_W-1:0]     activeChan,
  input  logic [CH_W-1:0]     rdChan,
  input  logic [2:0]          rdSel,
  output logic [31:0]         rdData,
  output logic [NUM_CH-1:0]   chanReady,
  output logic [31:0]         xferSrc,
  output logic [31:0]         xferDst,
  output logic [CNT_W-1:0]    xferCount,
  output logic [15:0]         xferCtl,
  output logic [NUM_CH-1:0]   irq
);
  localparam int FIELD_W = WIDE ? 21 : 16;
  localparam logic [15:0] CTL_MASK = WIDE ? 16'hFFE0 : 16'hF7E0;

  logic [31:0]      srcA  [NUM_CH];
  logic [31:0]      dstA  [NUM_CH];
  logic [31:0]      wSrcA [NUM_CH];
  logic [31:0]      wDstA [NUM_CH];
  logic [CNT_W-1:0] cntA  [NUM_CH];
  logic [CNT_W-1:0] remA  [NUM_CH];
  logic [15:0]      ctlA  [NUM_CH];

  logic [FIELD_W-1:0] fieldIn;
  logic [15:0]        ctlIn;
  logic               inImm;
  assign fieldIn = wrData[FIELD_W-1:0];
  assign ctlIn   = wrData[31:16] & CTL_MASK;
  assign inImm   = (ctlIn[13:11] == 3'd0);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam logic [CNT_W-1:0] MAXC =
      WIDE ? 22'h20_0000 : ((c == NUM_CH - 1) ? 22'h1_0000 : 22'h0_4000);
    logic [31:0]      srcR, dstR, wSrcR, wDstR;
    logic [CNT_W-1:0] cntR, remR, newCnt;
    logic [15:0]      ctlR;
    logic [1:0]       waitR;
    logic             irqR, hit, arm, mine, isImm, isVbl;

    assign hit    = wrEn && (wrChan == CH_W'(c));
    assign arm    = hit && (wrSel == 2'd2) && !ctlR[CTL_EN] && ctlIn[CTL_EN];
    assign mine   = (strobe.chan == CH_W'(c));
    assign newCnt = (fieldIn == '0) ? MAXC : CNT_W'(fieldIn);
    assign isImm  = (ctlR[13:11] == 3'd0);
    assign isVbl  = WIDE ? (ctlR[13:11] == 3'b001) : (ctlR[13:12] == 2'b01);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        srcR <= '0; dstR <= '0; wSrcR <= '0; wDstR <= '0;
        cntR <= RESET_COUNT; remR <= '0; ctlR <= '0;
        waitR <= '0; irqR <= 1'b0;
      end else begin
        irqR <= 1'b0;
        if (waitR != 2'd0) waitR <= waitR - 2'd1;
        if (strobe.wb && mine) begin
          wSrcR <= doneSrc;
          wDstR <= doneDst;
          remR  <= doneCount;
          if (strobe.finish) begin
            if (!(ctlR[CTL_REP] && !isImm)) ctlR[CTL_EN] <= 1'b0;
            if (ctlR[6:5] == 2'd3) wDstR <= dstR;
            if (ctlR[CTL_IRQ]) irqR <= 1'b1;
          end
        end
        if (vblankTick && ctlR[CTL_EN] && isVbl && remR == '0) remR <= cntR;
        if (hit) begin
          unique case (wrSel)
            2'd0: srcR <= wrData & ADDR_MASK;
            2'd1: dstR <= wrData & ADDR_MASK;
            2'd2: begin
              cntR <= newCnt;
              ctlR <= ctlIn;
              if (arm) begin
                wSrcR <= srcR;
                wDstR <= dstR;
                remR  <= inImm ? newCnt : '0;
                waitR <= START_WAIT;
              end
            end
            default: ;
          endcase
        end
      end
    end

    assign chanReady[c] = ctlR[CTL_EN] && (remR != '0) && (waitR == 2'd0);
    assign irq[c]  = irqR;
    assign srcA[c] = srcR;
    assign dstA[c] = dstR;
    assign wSrcA[c] = wSrcR;
    assign wDstA[c] = wDstR;
    assign cntA[c] = cntR;
    assign remA[c] = remR;
    assign ctlA[c] = ctlR;
  end

  always_comb begin
    unique case (rdSel)
      3'd0: rdData = srcA[rdChan];
      3'd1: rdData = dstA[rdChan];
      3'd2: rdData = {ctlA[rdChan], 16'h0};
      3'd3: rdData = 32'(cntA[rdChan]);
      3'd4: rdData = 32'(remA[rdChan]);
      3'd5: rdData = wSrcA[rdChan];
      3'd6: rdData = wDstA[rdChan];
      default: rdData = '0;
    endcase
  end

  assign xferSrc   = wSrcA[activeChan];
  assign xferDst   = wDstA[activeChan];
  assign xferCount = remA[activeChan];
  assign xferCtl   = ctlA[activeChan];
endmodule

// File: rtl/dmaseq_ctrl.sv
module dmaseq_ctrl
  import dmaseq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] chanReady,
  input  logic              unitDone,
  input  logic [CNT_W-1:0]  doneCount,
  output seqStrobe_t        strobe,
  output logic              xferStart,
  output logic [CH_W-1:0]   activeChan
);
  logic            busyR, startR, found;
  logic [CH_W-1:0] chanR, pickCh;

  always_comb begin
    found  = 1'b0;
    pickCh = '0;
    for (int c = NUM_CH - 1; c >= 0; c--) begin
      if (chanReady[c]) begin
        found  = 1'b1;
        pickCh = CH_W'(c);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyR <= 1'b0; startR <= 1'b0; chanR <= '0;
    end else begin
      startR <= 1'b0;
      if (!busyR && found) begin
        busyR  <= 1'b1;
        chanR  <= pickCh;
        startR <= 1'b1;
      end else if (busyR && unitDone) begin
        busyR <= 1'b0;
      end
    end
  end

  assign strobe.wb     = busyR && unitDone;
  assign strobe.finish = busyR && unitDone && (doneCount == '0);
  assign strobe.chan   = chanR;
  assign xferStart     = startR;
  assign activeChan    = chanR;
endmodule

// File: rtl/dma_sequencer.sv
module dma_sequencer
  import dmaseq_pkg::*;
#(
  parameter bit WIDE = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [CH_W-1:0]   wrChan,
  input  logic [1:0]        wrSel,
  input  logic [31:0]       wrData,
  input  logic [CH_W-1:0]   rdChan,
  input  logic [2:0]        rdSel,
  output logic [31:0]       rdData,
  input  logic              vblankTick,
  output logic              xferStart,
  output logic [CH_W-1:0]   xferChan,
  output logic [31:0]       xferSrc,
  output logic [31:0]       xferDst,
  output logic [CNT_W-1:0]  xferCount,
  output logic [15:0]       xferCtl,
  input  logic              unitDone,
  input  logic [31:0]       doneSrc,
  input  logic [31:0]       doneDst,
  input  logic [CNT_W-1:0]  doneCount,
  output logic [NUM_CH-1:0] irq
);
  seqStrobe_t        strobe;
  logic [NUM_CH-1:0] chanReady;

  dmaseq_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .chanReady(chanReady), .unitDone(unitDone),
    .doneCount(doneCount), .strobe(strobe), .xferStart(xferStart),
    .activeChan(xferChan)
  );

  dmaseq_regs #(.WIDE(WIDE)) uRegs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrChan(wrChan), .wrSel(wrSel),
    .wrData(wrData), .vblankTick(vblankTick), .strobe(strobe),
    .doneSrc(doneSrc), .doneDst(doneDst), .doneCount(doneCount),
    .activeChan(xferChan), .rdChan(rdChan), .rdSel(rdSel), .rdData(rdData),
    .chanReady(chanReady), .xferSrc(xferSrc), .xferDst(xferDst),
    .xferCount(xferCount), .xferCtl(xferCtl), .irq(irq)
  );
endmodule

// File: rtl/dmaseq_checker.sv
module dmaseq_checker
  import dmaseq_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [2:0]        rdSel,
  input logic [31:0]       rdData,
  input logic              xferStart,
  input logic              unitDone,
  input logic [CNT_W-1:0]  doneCount,
  input logic [NUM_CH-1:0] irq
);
  // R2: stored addresses never show masked-off bits
  assert_addr_mask_R2: assert property (@(posedge clk) disable iff (!rstN)
    (rdSel == 3'd0 || rdSel == 3'd1) |-> ((rdData & ~ADDR_MASK) == 32'h0));

  // R11: at most one channel interrupts at a time
  assert_irq_onehot_R11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(irq));

  // R11: an interrupt follows a final unit completion
  assert_irq_cause_R11: assert property (@(posedge clk) disable iff (!rstN)
    (irq != '0) |-> $past(unitDone && doneCount == '0));

  // R12: start is a single-cycle pulse
  assert_start_pulse_R12: assert property (@(posedge clk) disable iff (!rstN)
    xferStart |=> !xferStart);
endmodule

bind dma_sequencer dmaseq_checker uChk (
  .clk(clk), .rstN(rstN), .rdSel(rdSel), .rdData(rdData),
  .xferStart(xferStart), .unitDone(unitDone), .doneCount(doneCount), .irq(irq)
);

// File: tb/sim_dma_sequencer.sv
module sim_dma_sequencer;
  import dmaseq_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic             wrEn0 = 0, wrEn1 = 0;
  logic [1:0]       wrChan = 0, wrSel = 0;
  logic [31:0]      wrData = 0;
  logic [1:0]       rdChan = 0;
  logic [2:0]       rdSel = 0;
  logic [31:0]      rdData0, rdData1;
  logic             vblankTick = 0;
  logic             xferStart, xferStart1;
  logic [1:0]       xferChan, xferChan1;
  logic [31:0]      xferSrc, xferDst, xferSrc1, xferDst1;
  logic [21:0]      xferCount, xferCount1;
  logic [15:0]      xferCtl, xferCtl1;
  logic             unitDone = 0;
  logic [31:0]      doneSrc = 0, doneDst = 0;
  logic [21:0]      doneCount = 0;
  logic [3:0]       irq, irq1;

  dma_sequencer #(.WIDE(1'b1)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn0), .wrChan(wrChan), .wrSel(wrSel),
    .wrData(wrData), .rdChan(rdChan), .rdSel(rdSel), .rdData(rdData0),
    .vblankTick(vblankTick), .xferStart(xferStart), .xferChan(xferChan),
    .xferSrc(xferSrc), .xferDst(xferDst), .xferCount(xferCount),
    .xferCtl(xferCtl), .unitDone(unitDone), .doneSrc(doneSrc),
    .doneDst(doneDst), .doneCount(doneCount), .irq(irq)
  );

  dma_sequencer #(.WIDE(1'b0)) u1 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn1), .wrChan(wrChan), .wrSel(wrSel),
    .wrData(wrData), .rdChan(rdChan), .rdSel(rdSel), .rdData(rdData1),
    .vblankTick(1'b0), .xferStart(xferStart1), .xferChan(xferChan1),
    .xferSrc(xferSrc1), .xferDst(xferDst1), .xferCount(xferCount1),
    .xferCtl(xferCtl1), .unitDone(1'b0), .doneSrc(32'h0),
    .doneDst(32'h0), .doneCount(22'h0), .irq(irq1)
  );

  int checks = 0;
  int errors = 0;
  int startN = 0;
  logic [1:0] startLog [0:63];
  logic [21:0] firstCnt;
  logic [3:0] irqSeen = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // Transfer engine model: one unit takes one cycle after start.
  initial begin
    forever begin
      @(negedge clk);
      if (xferStart) begin
        if (startN < 64) startLog[startN] = xferChan;
        if (startN == 0) firstCnt = xferCount;
        startN++;
        doneSrc = xferSrc + 32'd4;
        doneDst = xferDst + 32'd4;
        doneCount = xferCount - 22'd1;
        @(negedge clk);
        unitDone = 1'b1;
        @(negedge clk);
        unitDone = 1'b0;
        irqSeen = irqSeen | irq;
      end
    end
  end

  task automatic wr(input bit inst, input logic [1:0] ch, input logic [1:0] sel,
                    input logic [31:0] d);
    @(negedge clk);
    wrChan = ch; wrSel = sel; wrData = d;
    if (inst) wrEn1 = 1'b1; else wrEn0 = 1'b1;
    @(negedge clk);
    wrEn0 = 1'b0; wrEn1 = 1'b0;
  endtask

  task automatic rd(input bit inst, input logic [1:0] ch, input logic [2:0] sel,
                    output logic [31:0] d);
    rdChan = ch; rdSel = sel;
    #1;
    d = inst ? rdData1 : rdData0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int c = 0; c < 4; c++) begin
      rd(0, 2'(c), 3'd3, d); check(d == 32'h200000, "R1 count", d, 32'h200000);
      rd(0, 2'(c), 3'd0, d); check(d == 0, "R1 src", d, 0);
      rd(0, 2'(c), 3'd2, d); check(d == 0, "R1 ctl", d, 0);
      rd(0, 2'(c), 3'd4, d); check(d == 0, "R1 remaining", d, 0);
    end
    check(!xferStart && irq == 0, "R1 idle", {27'h0, xferStart, irq}, 0);
  endtask

  task automatic t_addrMask();
    logic [31:0] d;
    wr(0, 2'd1, 2'd0, 32'hFFFF_FFFF);
    rd(0, 2'd1, 3'd0, d); check(d == 32'h0FFF_FFFE, "R2 src", d, 32'h0FFF_FFFE);
    wr(0, 2'd1, 2'd1, 32'h1234_5679);
    rd(0, 2'd1, 3'd1, d); check(d == 32'h0234_5678, "R2 dst", d, 32'h0234_5678);
  endtask

  task automatic t_wideCount();
    logic [31:0] d;
    wr(0, 2'd2, 2'd2, 32'h0012_3456);
    rd(0, 2'd2, 3'd3, d); check(d == 32'h12_3456, "R3 field", d, 32'h12_3456);
    wr(0, 2'd2, 2'd2, 32'h0000_0000);
    rd(0, 2'd2, 3'd3, d); check(d == 32'h20_0000, "R3 zero", d, 32'h20_0000);
    wr(0, 2'd2, 2'd2, 32'h7FFF_FFFF);
    rd(0, 2'd2, 3'd3, d); check(d == 32'h1F_FFFF, "R3 full", d, 32'h1F_FFFF);
    rd(0, 2'd2, 3'd2, d); check(d == 32'h7FE0_0000, "R5 wide mask", d, 32'h7FE0_0000);
    wr(0, 2'd2, 2'd2, 32'h0);
  endtask

  task automatic t_narrow();
    logic [31:0] d;
    wr(1, 2'd0, 2'd2, 32'h0000_0000);
    rd(1, 2'd0, 3'd3, d); check(d == 32'h4000, "R4 ch0 zero", d, 32'h4000);
    wr(1, 2'd3, 2'd2, 32'h0001_0000);
    rd(1, 2'd3, 3'd3, d); check(d == 32'h1_0000, "R4 ch3 zero", d, 32'h1_0000);
    wr(1, 2'd1, 2'd2, 32'h7FFF_1234);
    rd(1, 2'd1, 3'd3, d); check(d == 32'h1234, "R4 field", d, 32'h1234);
    rd(1, 2'd1, 3'd2, d); check(d == 32'h77E0_0000, "R5 narrow mask", d, 32'h77E0_0000);
  endtask

  task automatic t_immediate();
    logic [31:0] d;
    int lat;
    startN = 0; irqSeen = 0;
    wr(0, 2'd2, 2'd0, 32'h100);
    wr(0, 2'd2, 2'd1, 32'h200);
    wr(0, 2'd2, 2'd2, 32'h8000_0003);
    lat = 0;
    while (!xferStart && lat < 20) begin @(negedge clk); lat++; end
    check(lat == 4, "R7 start latency", 32'(lat), 32'd4);
    repeat (30) @(negedge clk);
    check(firstCnt == 22'd3, "R6 loaded remaining", 32'(firstCnt), 3);
    check(startN == 3, "R12 unit count", 32'(startN), 3);
    rd(0, 2'd2, 3'd4, d); check(d == 0, "R12 remaining", d, 0);
    rd(0, 2'd2, 3'd6, d); check(d == 32'h20C, "R12 working dst", d, 32'h20C);
    rd(0, 2'd2, 3'd5, d); check(d == 32'h10C, "R12 working src", d, 32'h10C);
    rd(0, 2'd2, 3'd2, d); check(d[31] == 1'b0, "R9 enable cleared", d, {1'b0, d[30:0]});
    check(irqSeen == 0, "R11 no irq when disabled", 32'(irqSeen), 0);
  endtask

  task automatic t_reloadIrq();
    logic [31:0] d;
    startN = 0; irqSeen = 0;
    wr(0, 2'd1, 2'd0, 32'h40);
    wr(0, 2'd1, 2'd1, 32'h400);
    wr(0, 2'd1, 2'd2, 32'hC260_0002);
    repeat (30) @(negedge clk);
    rd(0, 2'd1, 3'd6, d); check(d == 32'h400, "R10 dst reload", d, 32'h400);
    rd(0, 2'd1, 3'd2, d); check(d[31] == 1'b0, "R9 repeat+immediate clears", d, {1'b0, d[30:0]});
    check(irqSeen == 4'b0010, "R11 irq channel", 32'(irqSeen), 32'b0010);
  endtask

  task automatic t_priority();
    startN = 0;
    wr(0, 2'd3, 2'd2, 32'h8000_0002);
    wr(0, 2'd0, 2'd2, 32'h8000_0002);
    repeat (30) @(negedge clk);
    check(startN == 4, "R8 units", 32'(startN), 4);
    check(startLog[0] == 2'd3 && startLog[1] == 2'd0 && startLog[2] == 2'd0
          && startLog[3] == 2'd3, "R8 order",
          {24'h0, startLog[0], startLog[1], startLog[2], startLog[3]}, 32'b11000011);
  endtask

  task automatic t_vblankRewrite();
    logic [31:0] d;
    startN = 0;
    wr(0, 2'd0, 2'd0, 32'h10);
    wr(0, 2'd0, 2'd1, 32'h20);
    wr(0, 2'd0, 2'd2, 32'h8A00_0004);
    repeat (10) @(negedge clk);
    rd(0, 2'd0, 3'd4, d); check(d == 0, "R13 armed pending", d, 0);
    check(startN == 0, "R13 no start before tick", 32'(startN), 0);
    wr(0, 2'd0, 2'd0, 32'h80);
    wr(0, 2'd0, 2'd2, 32'h8A00_0007);
    rd(0, 2'd0, 3'd3, d); check(d == 7, "R6 rewrite count", d, 7);
    rd(0, 2'd0, 3'd0, d); check(d == 32'h80, "R6 rewrite src", d, 32'h80);
    rd(0, 2'd0, 3'd5, d); check(d == 32'h10, "R6 no re-arm", d, 32'h10);
    @(negedge clk); vblankTick = 1'b1;
    @(negedge clk); vblankTick = 1'b0;
    repeat (40) @(negedge clk);
    check(startN == 7, "R13 units after tick", 32'(startN), 7);
    rd(0, 2'd0, 3'd5, d); check(d == 32'h2C, "R13 working src", d, 32'h2C);
    rd(0, 2'd0, 3'd2, d); check(d[31] == 1'b1, "R9 repeat keeps enable", d, {1'b1, d[30:0]});
    wr(0, 2'd0, 2'd2, 32'h0);
  endtask

  initial begin
    bit done = 0;
    fork
      begin
        repeat (3) @(negedge clk);
        rstN = 1'b1;
        @(negedge clk);
        t_reset();
        t_addrMask();
        t_wideCount();
        t_narrow();
        t_immediate();
        t_reloadIrq();
        t_priority();
        t_vblankRewrite();
        done = 1;
      end
      begin
        repeat (20000) @(negedge clk);
      end
    join_any
    disable fork;
    if (!done) check(1'b0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule